// File: doc/BRIEF.md
# SMM and VGA Request Router

This block examines each memory request and returns a routing decision. It checks whether the address falls in one of three protected system-management windows. These are a low legacy window, a programmable extended segment just below a configurable top address, and a fixed high window. It also decides whether the requester may reach protected DRAM. The decision uses the request address, whether the request is a code fetch or a data access, the system-management qualifier carried with the request, and whether the request came from a processor or inbound from I/O or DMA. Control settings arrive as plain input ports.

A request that may not reach protected DRAM takes one of two paths. A denied legacy-window access falls through to the graphics bridge, or to the legacy downstream bus, where it is aborted. A denied access to the extended or high window is blocked locally as a master abort and sets a sticky error flag. Inbound accesses to protected windows never reach DRAM. Those results also carry a no-snoop indication. The result appears one clock after the request strobe.

Top module: `smm_vga_router`

## Requirements
- R1: A window decodes only when its enable is 1. Legacy spans 0xA0000..0xBFFFF. Extended spans from ext_top-ext_size up to but excluding ext_top. High spans 0xFEDA0000..0xFEDBFFFF. A request in no enabled window gets destination 0 (system memory) with rsp_addr equal to req_addr, and the qualifier has no effect on it.
- R2: A processor request to an enabled window that carries the qualifier (req_smm=1) is granted, subject to R5. A granted request gets destination 1 (protected DRAM).
- R3: A processor request without the qualifier is granted when smram_open=1 and the lock is not set.
- R4: A one-cycle lock_req pulse sets lock_state. Lowering lock_req does not clear it; only reset does. While lock_state=1, smram_open has no effect.
- R5: With data_close=1, a qualified data access (req_code=0) to the legacy window is denied. A qualified code fetch (req_code=1) there is still granted. data_close has no effect on the extended or high windows.
- R6: A denied processor legacy access gets destination 2 (VGA bridge) with rsp_port equal to the bit index when exactly one bit of bridge_vga is 1. When no bit or several bits are 1, it gets destination 3 (legacy bus).
- R7: A denied processor access to the extended or high window gets destination 4 (master abort) and sets smm_err.
- R8: A granted high-window access is sent to DRAM at 0xA0000 plus its offset within the high window. Granted legacy and extended accesses keep their address.
- R9: An inbound request (req_inbound=1) to an enabled window is never granted. For the legacy window it gets destination 3. For the extended and high windows it gets destination 4 and sets smm_err. In all these cases rsp_nosnoop=1, and rsp_nosnoop is 0 for every other result.
- R10: An inbound request with req_self=1 gets destination 4 before any window decode, and does not set smm_err.
- R11: smm_err stays set until err_clr=1 is sampled. If a new error occurs in the same cycle as err_clr, smm_err stays 1.
- R12: Each req_valid sampled at a clock edge produces rsp_valid=1 with its result after that edge. rsp_valid is 0 after any edge where req_valid was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Request address |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| req_smm | input | 1 | System-management qualifier |
| req_inbound | input | 1 | 1 = request from I/O or DMA |
| req_self | input | 1 | Inbound request targets the router itself |
| leg_en | input | 1 | Legacy window enable |
| ext_en | input | 1 | Extended segment enable |
| high_en | input | 1 | High window enable |
| ext_top | input | ADDR_W | Extended segment top (exclusive) |
| ext_size | input | ADDR_W | Extended segment size |
| smram_open | input | 1 | Open protected DRAM without the qualifier |
| data_close | input | 1 | Deny qualified data accesses to the legacy window |
| lock_req | input | 1 | Set the lock |
| bridge_vga | input | NBR | VGA-enable bit of each bridge |
| err_clr | input | 1 | Clear the sticky error |
| rsp_valid | output | 1 | Result valid |
| rsp_dest | output | 3 | 0 sysmem, 1 protected DRAM, 2 VGA bridge, 3 legacy bus, 4 master abort |
| rsp_port | output | PORT_W | Bridge index for destination 2 |
| rsp_addr | output | ADDR_W | Address forwarded to the target |
| rsp_nosnoop | output | 1 | Do not snoop this access |
| smm_err | output | 1 | Sticky invalid-access error |
| lock_state | output | 1 | Lock is set |

## Verification
The bench probes both edges of the extended segment. A design with an off-by-one compare there would steal a system-memory line or leak the top line. It sets data_close with code fetches and with extended-window data. A design that applied the close bit too broadly would turn granted accesses into aborts. It drives zero, one and two VGA-enable bits; a design that checked for any set bit, rather than for exactly one, would send traffic to the wrong port. It also covers the lock against later open settings, a self-targeted inbound request, and an error raised in the same cycle as its clear. Mistakes there show up as lost protection, stray error flags, or a cleared flag that should have stuck.

// File: rtl/smm_vga_router.sv
module smm_vga_router #(
  parameter int ADDR_W = 32,
  parameter int NBR    = 4,
  localparam int PORT_W = (NBR > 1) ? $clog2(NBR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_code,
  input  logic              req_smm,
  input  logic              req_inbound,
  input  logic              req_self,
  input  logic              leg_en,
  input  logic              ext_en,
  input  logic              high_en,
  input  logic [ADDR_W-1:0] ext_top,
  input  logic [ADDR_W-1:0] ext_size,
  input  logic              smram_open,
  input  logic              data_close,
  input  logic              lock_req,
  input  logic [NBR-1:0]    bridge_vga,
  input  logic              err_clr,
  output logic              rsp_valid,
  output logic [2:0]        rsp_dest,
  output logic [PORT_W-1:0] rsp_port,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_nosnoop,
  output logic              smm_err,
  output logic              lock_state
);
  localparam logic [2:0] D_SYS = 3'd0, D_SMM = 3'd1, D_VGA = 3'd2, D_BUS = 3'd3, D_ABT = 3'd4;
  localparam logic [ADDR_W-1:0] LEG_LO = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] LEG_HI = ADDR_W'(32'h000B_FFFF);
  localparam logic [ADDR_W-1:0] HI_LO  = ADDR_W'(32'hFEDA_0000);
  localparam logic [ADDR_W-1:0] HI_HI  = ADDR_W'(32'hFEDB_FFFF);

  logic lock_q;
  wire [ADDR_W-1:0] ext_lo = ext_top - ext_size;
  wire hit_leg = leg_en  && req_addr >= LEG_LO && req_addr <= LEG_HI;
  wire hit_hi  = high_en && req_addr >= HI_LO  && req_addr <= HI_HI;
  wire hit_ext = ext_en  && req_addr >= ext_lo && req_addr <  ext_top;
  wire any_hit = hit_leg | hit_hi | hit_ext;
  wire open_eff = smram_open & ~lock_q;
  wire grant = open_eff | (req_smm & ~(hit_leg & ~req_code & data_close));

  logic [PORT_W-1:0] vga_idx;
  logic [$clog2(NBR+1)-1:0] vga_cnt;
  always_comb begin
    vga_idx = '0;
    vga_cnt = '0;
    for (int i = 0; i < NBR; i++)
      if (bridge_vga[i]) begin
        vga_idx = PORT_W'(i);
        vga_cnt = vga_cnt + 1'b1;
      end
  end

  logic [2:0]        dest_c;
  logic [ADDR_W-1:0] addr_c;
  logic              err_c;
  always_comb begin
    dest_c = D_SYS;
    addr_c = req_addr;
    err_c  = 1'b0;
    if (req_inbound && req_self) begin
      dest_c = D_ABT;
    end else if (hit_leg) begin
      if (!req_inbound && grant) dest_c = D_SMM;
      else if (!req_inbound && vga_cnt == 1) dest_c = D_VGA;
      else dest_c = D_BUS;
    end else if (hit_hi || hit_ext) begin
      if (!req_inbound && grant) begin
        dest_c = D_SMM;
        if (hit_hi) addr_c = LEG_LO | ADDR_W'(req_addr[16:0]);
      end else begin
        dest_c = D_ABT;
        err_c  = 1'b1;
      end
    end
  end

  wire nosnoop_c = req_inbound & ~req_self & any_hit;
  wire err_set   = req_valid & err_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_dest    <= D_SYS;
      rsp_port    <= '0;
      rsp_addr    <= '0;
      rsp_nosnoop <= 1'b0;
      smm_err     <= 1'b0;
      lock_q      <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_dest    <= dest_c;
        rsp_port    <= vga_idx;
        rsp_addr    <= addr_c;
        rsp_nosnoop <= nosnoop_c;
      end
      smm_err <= err_set | (smm_err & ~err_clr);
      lock_q  <= lock_q | lock_req;
    end
  end

  assign lock_state = lock_q;

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) lock_q |=> lock_q);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) (smm_err && !err_clr) |=> smm_err);
  // R12
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid);
  // R12
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid);
  // R6
  vga_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_inbound && !grant && hit_leg) |=>
      ((rsp_dest == D_VGA) == ($countones($past(bridge_vga)) == 1)));
  // R9
  inbound_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_inbound) |=> rsp_dest != D_SMM);
endmodule

// File: tb/smm_vga_router_bench.sv
module smm_vga_router_bench;
  localparam int AW = 32, NB = 4, PW = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_code = 0, req_smm = 0, req_inbound = 0, req_self = 0;
  logic [AW-1:0] req_addr = 0, ext_top = 32'h0800_0000, ext_size = 32'h0010_0000;
  logic          leg_en = 1, ext_en = 1, high_en = 1, smram_open = 0, data_close = 0;
  logic          lock_req = 0, err_clr = 0;
  logic [NB-1:0] bridge_vga = 4'b0001;
  logic          rsp_valid, rsp_nosnoop, smm_err, lock_state;
  logic [2:0]    rsp_dest;
  logic [PW-1:0] rsp_port;
  logic [AW-1:0] rsp_addr;

  smm_vga_router #(.ADDR_W(AW), .NBR(NB)) u_smm_vga_router (.*);

  typedef struct {
    logic [2:0] dest; logic [PW-1:0] port; logic [AW-1:0] addr;
    logic ns; logic err; string tag;
  } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  logic m_err = 0, m_lock = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [AW-1:0] a, input logic code, smm, inb, slf, input string tag);
    exp_t e;
    bit l, h, x, g;
    int cnt = 0, idx = 0;
    e.dest = 0; e.port = 0; e.addr = a; e.ns = 0; e.err = 0; e.tag = tag;
    l = leg_en && a >= 32'hA0000 && a <= 32'hBFFFF;
    h = high_en && a >= 32'hFEDA0000 && a <= 32'hFEDBFFFF;
    x = ext_en && a >= ext_top - ext_size && a < ext_top;
    for (int i = 0; i < NB; i++) if (bridge_vga[i]) begin cnt++; idx = i; end
    if (smm) g = !(l && !code && data_close); else g = 0;
    if (smram_open && !m_lock) g = 1;
    if (inb && slf) e.dest = 4;
    else if (l) begin
      e.ns = inb;
      if (!inb && g) e.dest = 1;
      else if (!inb && cnt == 1) begin e.dest = 2; e.port = PW'(idx); end
      else e.dest = 3;
    end else if (h || x) begin
      e.ns = inb;
      if (!inb && g) begin e.dest = 1; if (h) e.addr = 32'hA0000 + (a - 32'hFEDA0000); end
      else begin e.dest = 4; e.err = 1; end
    end
    return e;
  endfunction

  task automatic do_req(input logic [AW-1:0] a, input logic code, smm, inb, slf, clr, input string tag);
    exp_t e;
    e = model(a, code, smm, inb, slf, tag);
    m_err = e.err | (m_err & ~clr);
    e.err = m_err;
    q.push_back(e);
    req_valid = 1; req_addr = a; req_code = code; req_smm = smm;
    req_inbound = inb; req_self = slf; err_clr = clr;
    @(negedge clk);
    req_valid = 0; err_clr = 0;
  endtask

  task automatic clear_err();
    err_clr = 1; m_err = 0;
    @(negedge clk);
    err_clr = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) chk(0, "R12", "unexpected rsp_valid", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(rsp_dest == e.dest, e.tag, "dest", rsp_dest, e.dest);
        if (e.dest == 2) chk(rsp_port == e.port, e.tag, "port", rsp_port, e.port);
        chk(rsp_addr == e.addr, e.tag, "addr", rsp_addr, e.addr);
        chk(rsp_nosnoop == e.ns, e.tag, "nosnoop", rsp_nosnoop, e.ns);
        chk(smm_err == e.err, e.tag, "smm_err", smm_err, e.err);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R12", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && smm_err == 0 && lock_state == 0, "R12", "reset state",
        {rsp_valid, smm_err, lock_state}, 0);
    rst_n = 1;
    @(negedge clk);
    do_req(32'h0000_1000, 0, 1, 0, 0, 0, "R1");
    do_req(32'h000A_0010, 0, 1, 0, 0, 0, "R2");
    do_req(32'h0801_0000, 0, 1, 0, 0, 0, "R2");
    bridge_vga = 4'b0100;
    do_req(32'h000B_0000, 0, 0, 0, 0, 0, "R6");
    bridge_vga = 4'b0000;
    do_req(32'h000B_0000, 0, 0, 0, 0, 0, "R6");
    bridge_vga = 4'b0110;
    do_req(32'h000A_0000, 1, 0, 0, 0, 0, "R6");
    bridge_vga = 4'b1000;
    data_close = 1;
    do_req(32'h000A_4000, 1, 1, 0, 0, 0, "R5");
    do_req(32'h000A_4000, 0, 1, 0, 0, 0, "R5");
    do_req(32'h07F0_0000, 0, 1, 0, 0, 0, "R5");
    do_req(32'hFEDA_0040, 0, 1, 0, 0, 0, "R5");
    data_close = 0;
    do_req(32'h07F8_0000, 0, 0, 0, 0, 0, "R7");
    clear_err();
    chk(smm_err == 0, "R11", "err after clear", smm_err, 0);
    do_req(32'hFEDB_0000, 1, 0, 0, 0, 0, "R7");
    clear_err();
    do_req(32'hFEDA_1234, 0, 1, 0, 0, 0, "R8");
    do_req(32'hFEDB_FFFF, 0, 1, 0, 0, 0, "R8");
    do_req(32'h07FF_FFFF, 0, 0, 0, 0, 0, "R1");
    do_req(32'h0800_0000, 0, 0, 0, 0, 0, "R1");
    do_req(32'h07F0_0000, 0, 0, 0, 0, 0, "R1");
    do_req(32'h07EF_FFFF, 0, 0, 0, 0, 0, "R1");
    clear_err();
    leg_en = 0; high_en = 0;
    do_req(32'h000A_0000, 0, 0, 0, 0, 0, "R1");
    do_req(32'hFEDA_0000, 0, 1, 0, 0, 0, "R1");
    leg_en = 1; high_en = 1;
    smram_open = 1;
    do_req(32'h000B_8000, 0, 0, 0, 0, 0, "R3");
    do_req(32'h07F0_0010, 1, 0, 0, 0, 0, "R3");
    lock_req = 1; m_lock = 1;
    @(negedge clk);
    lock_req = 0;
    @(negedge clk);
    chk(lock_state == 1, "R4", "lock_state after pulse", lock_state, 1);
    do_req(32'h07F0_0010, 0, 0, 0, 0, 0, "R4");
    do_req(32'h000A_0000, 0, 0, 0, 0, 0, "R4");
    clear_err();
    chk(lock_state == 1, "R4", "lock_state held", lock_state, 1);
    smram_open = 0;
    do_req(32'h000A_0000, 0, 1, 1, 0, 0, "R9");
    do_req(32'h07F0_0000, 0, 1, 1, 0, 0, "R9");
    do_req(32'hFEDA_0000, 0, 0, 1, 0, 0, "R9");
    clear_err();
    do_req(32'h0000_2000, 0, 1, 1, 0, 0, "R9");
    do_req(32'h07F0_0000, 0, 1, 1, 1, 0, "R10");
    do_req(32'hFEDA_0000, 0, 0, 0, 0, 1, "R11");
    @(negedge clk);
    chk(rsp_valid == 0, "R12", "idle rsp_valid", rsp_valid, 0);
    chk(q.size() == 0, "R12", "pending results", q.size(), 0);
    finish_run();
  end
endmodule